// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the send side of an interprocessor interrupt facility. Software sees a 64-bit command register split into two 32-bit words on a small memory-mapped bus. The high word holds only the 8-bit destination identifier. The low word holds the vector, the delivery mode, the trigger and level bits and the destination shorthand. A write to the low word is the trigger that sends a message.

When the trigger write is accepted, the block captures the whole command in one cycle. This includes the destination from the high word and a per-processor target mask expanded from the shorthand. The block then presents the captured command on an outbound message port with a valid/ready handshake. Until that port accepts the message, the delivery-status bit of the low word reads as busy, and further trigger writes are dropped. Software polls this bit before it issues the next command.

For a startup message, the vector holds a page number. The block also presents the matching start address on the port.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, the low word (offset 0x300) and the high word (offset 0x310) both read 0, and `msg_valid` is 0.
- R2: A write to offset 0x310 stores only bits [31:24] as the destination identifier. All other bits of that word read 0, and the write launches no message.
- R3: A write to offset 0x300 while the port is idle raises `msg_valid` in the next cycle. The message carries the vector from bits [7:0], the delivery mode from bits [10:8], the trigger-mode bit from bit 15 (1 = level) and the assert bit from bit 14 (1 = assert). Those bits read back from the low word.
- R4: Bit 12 of the low word reads 1 from the cycle after an accepted trigger write until the cycle after `msg_valid` and `msg_ready` are both high at a clock edge. While the port stalls, the message payload holds still.
- R5: A write to offset 0x300 while bit 12 reads 1 is ignored. The stored low word and the pending message are unchanged.
- R6: Shorthand 00 (bits [19:18]) addresses the destination identifier captured at the trigger write. `msg_dest` carries that identifier, and `msg_targets` has only bit `dest` set, or is all zero when `dest` is NUM_CPU or more. A later rewrite of the high word does not alter a pending message.
- R7: Shorthand 01 sets only bit `self_id` of `msg_targets`.
- R8: Shorthand 10 sets every bit of `msg_targets`.
- R9: Shorthand 11 sets every bit of `msg_targets` except bit `self_id`.
- R10: For delivery mode 110 (startup), `msg_start_addr` equals the vector shifted left by PAGE_SHIFT. For every other mode it is 0.
- R11: The remote-read status bits [17:16] always read 00 (invalid). Written values of bits [17:16] and bit 12 have no effect on readback.
- R12: Reads of any other offset return 0, and writes there change neither word and launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | 8 | Identifier of the local processor |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| msg_valid | output | 1 | Outbound message pending |
| msg_ready | input | 1 | Outbound port accepts the message |
| msg_vector | output | 8 | Vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level: 1 assert, 0 deassert |
| msg_trigger | output | 1 | Trigger mode: 1 level, 0 edge |
| msg_dest | output | 8 | Captured destination identifier |
| msg_targets | output | NUM_CPU | Expanded target mask |
| msg_start_addr | output | 8+PAGE_SHIFT | Startup start address |

## Verification
A register write takes effect at the clock edge where `bus_wr` is high. The message port outputs and the busy bit therefore change exactly one cycle after the trigger write. They change again one cycle after the edge where `msg_valid` and `msg_ready` are both high. `bus_rdata` is combinational from the stored state, so a read returns the state as soon as the address is set. The bench changes its inputs on the falling edge and samples one falling edge later, which is the first moment each registered result is due. It also checks that stalled messages and ignored writes leave every output untouched across several cycles.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_NAMED  = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic [11:0] rsvd_top;
    shorthand_e  shorthand;
    logic [1:0]  rr_status;
    logic        trig_level;
    logic        lvl_assert;
    logic        rsvd13;
    logic        busy;
    logic        rsvd11;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } cmd_low_t;

  localparam logic [31:0] LOW_WR_MASK  = 32'h000C_C7FF;
  localparam logic [31:0] HIGH_WR_MASK = 32'hFF00_0000;
  localparam logic [2:0]  MODE_STARTUP = 3'b110;

  // keep only software-writable bits of a low-word write
  function automatic cmd_low_t filter_low(input logic [31:0] w);
    return cmd_low_t'(w & LOW_WR_MASK);
  endfunction

endpackage

// File: rtl/ipi_target_decode.sv
module ipi_target_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  shorthand_e           shorthand,
  input  logic [7:0]           dest_id,
  input  logic [7:0]           self_id,
  output logic [NUM_CPU-1:0]   targets
);

  logic [NUM_CPU-1:0] self_hit;
  logic [NUM_CPU-1:0] dest_hit;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_hit
    assign self_hit[g] = (self_id == 8'(g));
    assign dest_hit[g] = (dest_id == 8'(g));
  end

  always_comb begin
    unique case (shorthand)
      SH_NAMED:  targets = dest_hit;
      SH_SELF:   targets = self_hit;
      SH_ALL:    targets = '1;
      SH_OTHERS: targets = ~self_hit;
      default:   targets = '0;
    endcase
  end

endmodule

// File: rtl/ipi_reg_file.sv
module ipi_reg_file
  import ipi_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] LOW_OFS  = 12'h300,
  parameter logic [11:0] HIGH_OFS = 12'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  output logic              launch,
  output logic [7:0]        dest_q,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] LOW_A  = ADDR_W'(LOW_OFS);
  localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(HIGH_OFS);

  cmd_low_t low_q;
  logic     hit_low, hit_high;

  assign hit_low  = (addr == LOW_A);
  assign hit_high = (addr == HIGH_A);
  assign launch   = wr && hit_low && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      dest_q <= '0;
    end else begin
      if (launch)          low_q  <= filter_low(wdata);
      if (wr && hit_high)  dest_q <= wdata[31:24];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_low) begin
      rdata     = low_q;
      rdata[12] = busy;
    end else if (hit_high) begin
      rdata = {dest_q, 24'h0} & HIGH_WR_MASK;
    end
  end

endmodule

// File: rtl/ipi_msg_port.sv
module ipi_msg_port #(
  parameter int NUM_CPU = 8,
  parameter int START_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [7:0]         in_vector,
  input  logic [2:0]         in_mode,
  input  logic               in_level,
  input  logic               in_trigger,
  input  logic [7:0]         in_dest,
  input  logic [NUM_CPU-1:0] in_targets,
  input  logic [START_W-1:0] in_start,
  input  logic               ready,
  output logic               valid,
  output logic [7:0]         vector,
  output logic [2:0]         mode,
  output logic               level,
  output logic               trigger,
  output logic [7:0]         dest,
  output logic [NUM_CPU-1:0] targets,
  output logic [START_W-1:0] start_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      vector     <= '0;
      mode       <= '0;
      level      <= 1'b0;
      trigger    <= 1'b0;
      dest       <= '0;
      targets    <= '0;
      start_addr <= '0;
    end else if (launch) begin
      valid      <= 1'b1;
      vector     <= in_vector;
      mode       <= in_mode;
      level      <= in_level;
      trigger    <= in_trigger;
      dest       <= in_dest;
      targets    <= in_targets;
      start_addr <= in_start;
    end else if (valid && ready) begin
      valid      <= 1'b0;
    end
  end

endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_CPU    = 8,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [11:0] LOW_OFS    = 12'h300,
  parameter logic [11:0] HIGH_OFS   = 12'h310,
  localparam int         START_W    = 8 + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         self_id,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector,
  output logic [2:0]         msg_mode,
  output logic               msg_level,
  output logic               msg_trigger,
  output logic [7:0]         msg_dest,
  output logic [NUM_CPU-1:0] msg_targets,
  output logic [START_W-1:0] msg_start_addr
);

  // page number to byte address, only for startup messages
  function automatic logic [START_W-1:0] start_of(input logic [2:0] m,
                                                  input logic [7:0] v);
    return (m == MODE_STARTUP) ? ({{PAGE_SHIFT{1'b0}}, v} << PAGE_SHIFT) : '0;
  endfunction

  // named internal events, also used by the checker
  logic               launch;
  logic               busy;
  logic [7:0]         dest_q;
  logic [NUM_CPU-1:0] next_targets;
  shorthand_e         next_sh;

  assign busy    = msg_valid;
  assign next_sh = shorthand_e'(bus_wdata[19:18]);

  ipi_reg_file #(
    .ADDR_W(ADDR_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .busy(busy), .launch(launch),
    .dest_q(dest_q), .rdata(bus_rdata)
  );

  ipi_target_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .shorthand(next_sh), .dest_id(dest_q), .self_id(self_id),
    .targets(next_targets)
  );

  ipi_msg_port #(.NUM_CPU(NUM_CPU), .START_W(START_W)) u_port (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .in_vector(bus_wdata[7:0]), .in_mode(bus_wdata[10:8]),
    .in_level(bus_wdata[14]), .in_trigger(bus_wdata[15]),
    .in_dest(dest_q), .in_targets(next_targets),
    .in_start(start_of(bus_wdata[10:8], bus_wdata[7:0])),
    .ready(msg_ready), .valid(msg_valid),
    .vector(msg_vector), .mode(msg_mode), .level(msg_level),
    .trigger(msg_trigger), .dest(msg_dest), .targets(msg_targets),
    .start_addr(msg_start_addr)
  );

endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
  parameter int          ADDR_W   = 12,
  parameter int          NUM_CPU  = 8,
  parameter logic [11:0] LOW_OFS  = 12'h300
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               launch,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [7:0]         msg_vector,
  input logic [NUM_CPU-1:0] msg_targets
);

  // R3
  launch_raises_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> msg_valid);

  // R4
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_targets)));

  // R4
  accept_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  // R5
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !launch);

  // R4
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(LOW_OFS)) |-> (bus_rdata[12] == msg_valid));

  // R11
  rr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(LOW_OFS)) |-> (bus_rdata[17:16] == 2'b00));

endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(
  .ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .LOW_OFS(LOW_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .launch(launch), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_targets(msg_targets)
);

// File: tb/test_ipi_cmd_reg.sv
`timescale 1ns/1ps
module test_ipi_cmd_reg;

  localparam int ADDR_W = 12;
  localparam int NUM_CPU = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int START_W = 8 + PAGE_SHIFT;
  localparam logic [11:0] LOW = 12'h300;
  localparam logic [11:0] HIGH = 12'h310;
  localparam logic [7:0] SELF = 8'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic msg_valid, msg_ready = 1'b0;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;
  logic msg_level, msg_trigger;
  logic [NUM_CPU-1:0] msg_targets;
  logic [START_W-1:0] msg_start_addr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ipi_cmd_reg #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .PAGE_SHIFT(PAGE_SHIFT)) i_ipi_cmd_reg (
    .clk(clk), .rst_n(rst_n), .self_id(SELF), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_level(msg_level), .msg_trigger(msg_trigger), .msg_dest(msg_dest),
    .msg_targets(msg_targets), .msg_start_addr(msg_start_addr)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", what, got, exp);
    end
  endtask

  // one write, visible from the following falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(LOW, d);  chk("R1 low after reset", d, 0);
    rd(HIGH, d); chk("R1 high after reset", d, 0);
    chk("R1 valid after reset", 32'(msg_valid), 0);
  endtask

  task automatic t_high_only();
    logic [31:0] d;
    wr(HIGH, 32'hA5FF_FFFF);
    rd(HIGH, d); chk("R2 high keeps [31:24]", d, 32'hA500_0000);
    chk("R2 no launch", 32'(msg_valid), 0);
  endtask

  task automatic t_launch_startup();
    logic [31:0] d;
    wr(HIGH, 32'h0500_0000);
    wr(LOW, 32'h0000_C6AB);
    chk("R3 valid", 32'(msg_valid), 1);
    chk("R3 vector", 32'(msg_vector), 32'hAB);
    chk("R3 mode", 32'(msg_mode), 6);
    chk("R3 level", 32'(msg_level), 1);
    chk("R3 trigger", 32'(msg_trigger), 1);
    chk("R6 dest", 32'(msg_dest), 5);
    chk("R6 targets named", 32'(msg_targets), 32'h20);
    chk("R10 start addr", 32'(msg_start_addr), 32'h000A_B000);
    rd(LOW, d); chk("R3 readback with busy", d, 32'h0000_D6AB);
    accept();
    chk("R4 valid drops", 32'(msg_valid), 0);
    rd(LOW, d); chk("R4 busy clear", d, 32'h0000_C6AB);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    wr(LOW, 32'h0000_0011);
    repeat (3) @(negedge clk);
    chk("R4 stalled valid", 32'(msg_valid), 1);
    rd(LOW, d); chk("R4 busy during stall", d, 32'h0000_1011);
    wr(LOW, 32'h000C_0522);
    rd(LOW, d); chk("R5 low unchanged", d, 32'h0000_1011);
    chk("R5 vector unchanged", 32'(msg_vector), 32'h11);
    chk("R5 targets unchanged", 32'(msg_targets), 32'h20);
    wr(HIGH, 32'h0700_0000);
    chk("R6 pending dest kept", 32'(msg_dest), 5);
    rd(HIGH, d); chk("R6 high rewritten", d, 32'h0700_0000);
    chk("R10 start zero for fixed", 32'(msg_start_addr), 0);
    accept();
    chk("R4 valid drops after stall", 32'(msg_valid), 0);
    rd(LOW, d); chk("R4 busy clear after stall", d, 32'h0000_0011);
  endtask

  task automatic t_shorthand(input logic [1:0] sh, input logic [31:0] exp, input string tag);
    wr(LOW, {12'h0, sh, 18'h00030});
    chk(tag, 32'(msg_targets), exp);
    accept();
  endtask

  task automatic t_out_of_range();
    wr(HIGH, 32'h2000_0000);
    wr(LOW, 32'h0000_0033);
    chk("R6 dest out of range", 32'(msg_dest), 32'h20);
    chk("R6 targets empty", 32'(msg_targets), 0);
    accept();
  endtask

  task automatic t_rr_bits();
    logic [31:0] d;
    wr(LOW, 32'h0003_1040);
    rd(LOW, d); chk("R11 rr bits zero while busy", d, 32'h0000_1040);
    accept();
    rd(LOW, d); chk("R11 bit12 write no effect", d, 32'h0000_0040);
  endtask

  task automatic t_other_addr();
    logic [31:0] d;
    wr(12'h320, 32'hFFFF_FFFF);
    chk("R12 no launch", 32'(msg_valid), 0);
    rd(12'h320, d); chk("R12 other reads zero", d, 0);
    rd(LOW, d);  chk("R12 low kept", d, 32'h0000_0040);
    rd(HIGH, d); chk("R12 high kept", d, 32'h2000_0000);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high_only();
    t_launch_startup();
    t_busy_ignore();
    wr(HIGH, 32'h0500_0000);
    t_shorthand(2'b00, 32'h20, "R6 named");
    t_shorthand(2'b01, 32'h08, "R7 self");
    t_shorthand(2'b10, 32'hFF, "R8 all");
    t_shorthand(2'b11, 32'hF7, "R9 others");
    t_out_of_range();
    t_rr_bits();
    t_other_addr();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule